// File: doc/BRIEF.md
# Peripheral Chip-Select and Wait-State Generator

This block sits on the address side of a small bus controller. Software programs a peripheral base address. The block then maps six consecutive 256-byte windows above that base onto six active-low select lines. One window in the middle of the run is left unused, so it drives no select. Each select line is wired to a pin that it shares with a general-purpose I/O function. A select reaches its pin only when both I/O configuration bits of that pin are clear.

When an access hits any peripheral window, the block stretches the bus cycle through `cycle_ext`. The stretch lasts for a programmed number of wait states, picked by a three-bit code from a nonlinear table. A ready-mode bit decides whether the cycle must also wait for an external ready line. A separate low-memory select stays off after reset and is switched on by the first write to its register. From then on it marks the bottom of the address space.

Top module: `pcs_waitgen`

## Requirements
- R1: With block offset `k = addr[19:8] - base` (12-bit, modulo), select bits 0 to 3 of `pcs_n` go low for `k` = 0, 1, 2 and 3 respectively. Each window covers 256 bytes.
- R2: For `k` = 4 (base+1024 to base+1279), and for any `k` above 6, no bit of `pcs_n` goes low.
- R3: `pcs_n[4]` goes low for `k` = 5 (base+1280 to base+1535). `pcs_n[5]` goes low for `k` = 6 (base+1536 to base+1791).
- R4: `pcs_n` is all ones whenever `bus_cyc` is low. At most one bit of `pcs_n` is low at any time.
- R5: Bit `g` of `pcs_n` can go low only when `pio_mode[g]` and `pio_dir[g]` are both 0. Otherwise that bit stays high.
- R6: The control register (`cfg_sel` = 1) holds four fields: bit 3 is the high code bit, bit 2 is the ready-ignore flag, and bits 1:0 are the low code bits. The wait code `{bit3, bit1, bit0}`, for values 0 to 7, gives 0, 1, 2, 3, 5, 7, 9 and 15 wait states.
- R7: Take an access to be a rise of `bus_cyc` while the address hits one of the six peripheral windows, whether or not the pin is gated. With ready ignored (bit 2 = 1), `cycle_ext` is high in exactly the first N cycles of that access, where N is the programmed count.
- R8: With ready required (bit 2 = 0), `cycle_ext` stays high in cycle i of the access while i < N or while `ext_rdy` is low. Once it drops, it stays low until `bus_cyc` falls.
- R9: Reading the control register returns bits 6:4 as 1, bits 3:0 as written, and all other bits as 0.
- R10: The base register (`cfg_sel` = 0) reads back the full written word. Bits 11:0 of that word are the base block, which equals address bits 19:8.
- R11: `lcs_n` is high after reset. Any write to `cfg_sel` = 2 enables it permanently. Once enabled, `lcs_n` is low while `bus_cyc` is high and `addr` < 1024.
- R12: After reset, the base register reads 0, the control register reads 0x0070, and `cycle_ext` is low.
- R13: An access that hits no peripheral window never raises `cycle_ext`, even when ready is required and `ext_rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 20 | Bus address |
| bus_cyc | input | 1 | High for the duration of a bus cycle |
| ext_rdy | input | 1 | External ready |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 control, 2 low-memory |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_sel` |
| pio_mode | input | 6 | Per-pin I/O mode bits |
| pio_dir | input | 6 | Per-pin I/O direction bits |
| pcs_n | output | 6 | Active-low peripheral selects |
| lcs_n | output | 1 | Active-low low-memory select |
| cycle_ext | output | 1 | Bus cycle extend request |

## Verification
The selects, `lcs_n` and `cfg_rdata` are combinational. They are due in the same cycle the inputs are applied, and the bench checks them at the following falling edge. A register write takes effect at the rising edge that samples `cfg_we`, so its readback is checked one cycle later. `cycle_ext` is checked at every falling edge of an access, counting from the first cycle `bus_cyc` is high. That cycle has index 0, and its expected value is whether the index lies below the larger of N and the ready delay. Ready is changed only just after a rising edge.

// File: rtl/pcs_pkg.sv
// Package pcs_pkg
// Shared constants, the control-field layout and the wait-code table for
// the peripheral chip-select block. Assumes six selects over seven slots.
package pcs_pkg;

    localparam int unsigned NUM_CS    = 6;
    localparam int unsigned NUM_SLOTS = 7;
    localparam int unsigned SKIP_SLOT = 4;
    localparam int unsigned WAIT_W    = 4;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_LMEM = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    // Stored control field, bit 3 down to bit 0
    typedef struct packed {
        logic       code_hi;
        logic       rdy_ign;
        logic [1:0] code_lo;
    } ctrl_t;

    // Nonlinear wait-state table
    function automatic logic [WAIT_W-1:0] wait_count(input logic [2:0] code);
        logic [WAIT_W-1:0] n;
        case (code)
            3'd0:    n = 4'd0;
            3'd1:    n = 4'd1;
            3'd2:    n = 4'd2;
            3'd3:    n = 4'd3;
            3'd4:    n = 4'd5;
            3'd5:    n = 4'd7;
            3'd6:    n = 4'd9;
            default: n = 4'd15;
        endcase
        return n;
    endfunction

    // Window slot served by select index g (skips the unused slot)
    function automatic int unsigned slot_of_cs(input int unsigned g);
        return (g < SKIP_SLOT) ? g : g + 1;
    endfunction

endpackage

// File: rtl/pcs_cfg_regs.sv
// Module pcs_cfg_regs
// Holds the base, control and low-memory registers and drives readback.
// Assumes one write per cycle; the low-memory enable is sticky until reset.
module pcs_cfg_regs
    import pcs_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [REG_W-1:0] base_word,
    output ctrl_t            ctrl,
    output logic             lmem_en
);

    logic [REG_W-1:0] lmem_word;

    // Register update on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_word <= '0;
            ctrl      <= '0;
            lmem_en   <= 1'b0;
            lmem_word <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_BASE: base_word <= cfg_wdata;
                SEL_CTRL: ctrl      <= ctrl_t'(cfg_wdata[3:0]);
                SEL_LMEM: begin
                    lmem_word <= cfg_wdata;
                    lmem_en   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Readback mux; reserved control bits read as ones
    always_comb begin
        case (cfg_sel_e'(cfg_sel))
            SEL_BASE: cfg_rdata = base_word;
            SEL_CTRL: cfg_rdata = REG_W'({3'b111, ctrl});
            SEL_LMEM: cfg_rdata = lmem_word;
            default:  cfg_rdata = '0;
        endcase
    end

    p_ctrl_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == SEL_CTRL) |-> (cfg_rdata[6:4] == 3'b111));

    p_lmem_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lmem_en) |-> lmem_en);

    p_lmem_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_LMEM) |=> lmem_en);

endmodule

// File: rtl/pcs_decode.sv
// Module pcs_decode
// Compares the address block number against the base and drives the six
// gated active-low selects. Assumes the base sits at a 256-byte boundary.
module pcs_decode
    import pcs_pkg::*;
#(
    parameter int unsigned BLK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  addr_blk,
    input  logic [BLK_W-1:0]  base_blk,
    input  logic              bus_cyc,
    input  logic [NUM_CS-1:0] pio_mode,
    input  logic [NUM_CS-1:0] pio_dir,
    output logic              win_hit,
    output logic [NUM_CS-1:0] pcs_n
);

    logic [BLK_W-1:0]  offs;
    logic [NUM_CS-1:0] raw;

    // Window offset relative to the base
    always_comb offs = addr_blk - base_blk;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        localparam int unsigned SLOT = slot_of_cs(g);
        // Raw window match and pin gating for one select
        always_comb begin
            raw[g]   = (offs == BLK_W'(SLOT));
            pcs_n[g] = !(bus_cyc && raw[g] && !pio_mode[g] && !pio_dir[g]);
        end
    end

    // Any peripheral window matched
    always_comb win_hit = |raw;

    p_skip_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (offs == BLK_W'(SKIP_SLOT)) |-> (&pcs_n && !win_hit));

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pio_mode | pio_dir) & ~pcs_n) == '0);

endmodule

// File: rtl/pcs_wait_ctrl.sv
// Module pcs_wait_ctrl
// Loads the decoded wait count at the start of a hit access and holds
// cycle_ext until the count is spent and, if required, ready is high.
// Assumes bus_cyc is low for at least one cycle between accesses.
module pcs_wait_ctrl
    import pcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cyc,
    input  logic       win_hit,
    input  logic [2:0] code,
    input  logic       need_rdy,
    input  logic       ext_rdy,
    output logic       cycle_ext
);

    logic              cyc_q;
    logic              acc_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              start;
    logic              active;
    logic [WAIT_W-1:0] wait_n;
    logic [WAIT_W-1:0] left;

    // Start detection and remaining-wait selection
    always_comb begin
        start     = bus_cyc && !cyc_q;
        wait_n    = wait_count(code);
        active    = start ? win_hit : acc_q;
        left      = start ? wait_n : cnt_q;
        cycle_ext = bus_cyc && active && ((left != '0) || (need_rdy && !ext_rdy));
    end

    // Access and counter state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= 1'b0;
            acc_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            cyc_q <= bus_cyc;
            acc_q <= cycle_ext;
            cnt_q <= cycle_ext ? (left - WAIT_W'(left != '0)) : '0;
        end
    end

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && win_hit) |=> (cnt_q == ($past(wait_n) - WAIT_W'($past(wait_n) != '0))));

    p_cnt_holds_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && bus_cyc) |-> cycle_ext);

    p_stay_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_cyc) && bus_cyc && !$past(cycle_ext)) |-> !cycle_ext);

    p_miss_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !win_hit) |-> !cycle_ext);

endmodule

// File: rtl/pcs_waitgen.sv
// Module pcs_waitgen
// Top of the peripheral chip-select and wait-state generator: register
// file, window decoder, wait controller and the low-memory select.
// Assumes addr is stable for the whole of a bus cycle.
module pcs_waitgen
    import pcs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned REG_W     = 16,
    parameter int unsigned LOW_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_cyc,
    input  logic              ext_rdy,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [5:0]        pio_mode,
    input  logic [5:0]        pio_dir,
    output logic [5:0]        pcs_n,
    output logic              lcs_n,
    output logic              cycle_ext
);

    localparam int unsigned BLK_W = ADDR_W - 8;

    logic [REG_W-1:0] base_word;
    ctrl_t            ctrl;
    logic             lmem_en;
    logic             win_hit;

    pcs_cfg_regs #(.REG_W(REG_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .base_word (base_word),
        .ctrl      (ctrl),
        .lmem_en   (lmem_en)
    );

    pcs_decode #(.BLK_W(BLK_W)) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_blk (addr[ADDR_W-1:8]),
        .base_blk (base_word[BLK_W-1:0]),
        .bus_cyc  (bus_cyc),
        .pio_mode (pio_mode),
        .pio_dir  (pio_dir),
        .win_hit  (win_hit),
        .pcs_n    (pcs_n)
    );

    pcs_wait_ctrl i_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cyc   (bus_cyc),
        .win_hit   (win_hit),
        .code      ({ctrl.code_hi, ctrl.code_lo}),
        .need_rdy  (!ctrl.rdy_ign),
        .ext_rdy   (ext_rdy),
        .cycle_ext (cycle_ext)
    );

    // Low-memory select once enabled
    always_comb lcs_n = !(bus_cyc && lmem_en && (addr < ADDR_W'(LOW_BYTES)));

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (&pcs_n && lcs_n && !cycle_ext));

endmodule

// File: tb/test_pcs_waitgen.sv
// Bench for pcs_waitgen: directed corners plus seeded random decode checks.
module test_pcs_waitgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        bus_cyc = 1'b0;
    logic        ext_rdy = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [5:0]  pio_mode = '0;
    logic [5:0]  pio_dir = '0;
    logic [5:0]  pcs_n;
    logic        lcs_n;
    logic        cycle_ext;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pcs_waitgen i_pcs_waitgen (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bus_cyc(bus_cyc),
        .ext_rdy(ext_rdy), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pio_mode(pio_mode),
        .pio_dir(pio_dir), .pcs_n(pcs_n), .lcs_n(lcs_n), .cycle_ext(cycle_ext)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int wait_of(input int code);
        case (code)
            0: return 0;  1: return 1;  2: return 2;  3: return 3;
            4: return 5;  5: return 7;  6: return 9;  default: return 15;
        endcase
    endfunction

    function automatic logic [5:0] exp_pcs(input int a, input int b,
                                           input logic [5:0] m, input logic [5:0] d,
                                           input bit cyc);
        logic [5:0] r = 6'h3F;
        int k = ((a >> 8) - b) & 32'hFFF;
        for (int g = 0; g < 6; g++) begin
            int slot = (g < 4) ? g : g + 1;
            if (cyc && k == slot && !m[g] && !d[g]) r[g] = 1'b0;
        end
        return r;
    endfunction

    task automatic wr(input int sel, input int data);
        cfg_sel = 2'(sel); cfg_wdata = 16'(data); cfg_we = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string req, input int sel, input int exp);
        cfg_sel = 2'(sel);
        @(negedge clk);
        chk(req, int'(cfg_rdata), exp);
        @(posedge clk); #1;
    endtask

    task automatic set_ctrl(input int code, input bit ign);
        wr(1, ((code >> 2) & 1) << 3 | int'(ign) << 2 | (code & 3));
    endtask

    // One access; cycle_ext expected high in cycle i while i < lim
    task automatic run_access(input string req, input int a, input int dly,
                              input int lim);
        addr = 20'(a); bus_cyc = 1'b1; ext_rdy = (dly == 0);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            chk(req, int'(cycle_ext), int'(i < lim));
            @(posedge clk); #1;
            ext_rdy = (i + 1 >= dly);
        end
        bus_cyc = 1'b0; ext_rdy = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12: reset state
        @(negedge clk);
        chk("R12 pcs idle", int'(pcs_n), 'h3F);
        chk("R12 ext idle", int'(cycle_ext), 0);
        @(posedge clk); #1;
        rd("R12 base reset", 0, 0);
        rd("R12 ctrl reset", 1, 'h70);

        // R11: low-memory select off before any write
        addr = 20'h00100; bus_cyc = 1'b1;
        @(negedge clk); chk("R11 lcs off", int'(lcs_n), 1);
        @(posedge clk); #1; bus_cyc = 1'b0;
        @(posedge clk); #1;

        // R10, R9: register readback
        base = 'h123;
        wr(0, 'hA000 | base);
        rd("R10 base readback", 0, 'hA000 | base);
        wr(1, 'hFFFF);
        rd("R9 ctrl reserved", 1, 'h7F);
        wr(1, 'h0005);
        rd("R9 ctrl fields", 1, 'h75);

        // R1, R2, R3: each slot and neighbours
        for (int k = -1; k < 9; k++) begin
            addr = 20'(((base + k) << 8) + 'h80); bus_cyc = 1'b1;
            @(negedge clk);
            chk(k == 4 ? "R2 skip slot" : (k < 4 ? "R1 window" : "R3 window"),
                int'(pcs_n), int'(exp_pcs(int'(addr), base, 6'h0, 6'h0, 1'b1)));
            @(posedge clk); #1;
            bus_cyc = 1'b0;
            @(negedge clk);
            chk("R4 idle", int'(pcs_n), 'h3F);
            @(posedge clk); #1;
        end

        // R1, R3: window edges
        addr = 20'((base << 8) + 255); bus_cyc = 1'b1;
        @(negedge clk); chk("R1 top edge", int'(pcs_n), 'h3E);
        @(posedge clk); #1; addr = 20'((base << 8) + 1791);
        @(negedge clk); chk("R3 top edge", int'(pcs_n), 'h1F);
        @(posedge clk); #1; addr = 20'((base << 8) + 1792);
        @(negedge clk); chk("R2 past end", int'(pcs_n), 'h3F);
        @(posedge clk); #1; bus_cyc = 1'b0;

        // R5, R4: random decode with pin gating
        for (int n = 0; n < 60; n++) begin
            int b = int'($urandom % 3000);
            int off = int'($urandom % 2304) - 256;
            wr(0, b);
            pio_mode = ($urandom % 3 == 0) ? 6'($urandom) : 6'h0;
            pio_dir  = ($urandom % 3 == 0) ? 6'($urandom) : 6'h0;
            addr = 20'((b << 8) + off);
            bus_cyc = 1'($urandom % 4 != 0);
            @(negedge clk);
            chk("R5 random decode", int'(pcs_n),
                int'(exp_pcs(int'(addr), b, pio_mode, pio_dir, bus_cyc)));
            @(posedge clk); #1;
            bus_cyc = 1'b0;
            @(posedge clk); #1;
        end
        pio_mode = '0; pio_dir = '0;
        wr(0, base);

        // R6, R7: every code with ready ignored
        for (int c = 0; c < 8; c++) begin
            set_ctrl(c, 1'b1);
            run_access("R7 wait count", (base + 1) << 8, 12, wait_of(c));
        end

        // R7: gated pin still waits
        pio_mode = 6'h3F;
        set_ctrl(2, 1'b1);
        run_access("R7 gated pin wait", (base + 6) << 8, 0, 2);
        pio_mode = '0;

        // R8: ready required with random delays
        for (int n = 0; n < 12; n++) begin
            int c = int'($urandom % 8);
            int dly = int'($urandom % 20);
            set_ctrl(c, 1'b0);
            run_access("R8 ready wait", (base + 5) << 8, dly,
                       (wait_of(c) > dly) ? wait_of(c) : dly);
        end

        // R13: miss never extends
        set_ctrl(7, 1'b0);
        run_access("R13 miss reserved", (base + 4) << 8, 10, 0);
        run_access("R13 miss outside", (base + 9) << 8, 10, 0);

        // R11: enable by write, then range check
        wr(2, 0);
        wr(0, 'h400);
        addr = 20'h003FF; bus_cyc = 1'b1;
        @(negedge clk); chk("R11 lcs in range", int'(lcs_n), 0);
        @(posedge clk); #1; addr = 20'h00400;
        @(negedge clk); chk("R11 lcs above", int'(lcs_n), 1);
        @(posedge clk); #1; addr = 20'h00000; bus_cyc = 1'b0;
        @(negedge clk); chk("R11 lcs idle", int'(lcs_n), 1);
        @(posedge clk); #1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule